// File: doc/BRIEF.md
# Free-Running Timer with Overflow Flag and Capture/Compare Select

This block is an up-counter with two channel registers and one 8-bit option/status register. The counter runs while an external enable is high and sits at zero while the enable is low. Each channel register acts as a compare register by default. It raises a one-cycle match output when the running count equals its value. In free-running mode a select bit turns the channel into a capture register instead, and the register then latches the count on a rising edge of that channel's trigger input.

The option register carries a sticky overflow flag. The flag sets when the count wraps from all-ones to zero, but only in the free-running or pulse-width-measurement mode. An overflow interrupt pulse is raised together with it. Software can clear the flag but cannot set it. Dropping the enable also clears it. The select bits are frozen while the counter runs.

Software reaches the block over a byte-wide register bus. Whole-byte writes, single-bit writes and reads all work on the same address map. A read returns data on the cycle after the read strobe.

Top module: `ftmr_top`

## Requirements
- R1: After reset the option register (address 0) reads 0x00, the count is 0 and the overflow interrupt is low.
- R2: With the enable low the count is 0 after every clock edge. With the enable high it rises by one per clock edge and wraps from all-ones (2^CNT_W-1, CNT_W=16 by default) to 0.
- R3: Option bit 0 is the overflow flag. It sets on the edge where the count wraps, but only when the mode input is 0 (free-running) or 1 (pulse-width measurement). Modes 2 and 3 never set it.
- R4: The overflow interrupt is high for exactly one cycle, starting on the same edge that sets the flag. It never pulses in modes 2 or 3.
- R5: Reading the option register does not clear the overflow flag.
- R6: Writing 1 to bit 0, by byte write or bit write, leaves the flag unchanged. Writing 0 clears it. A low enable clears it.
- R7: When a wrap and a software write of 0 to bit 0 fall on the same edge, the flag ends up set.
- R8: Bit 4 selects capture (1) or compare (0) for channel 0, and bit 5 does the same for channel 1. Bits 1-3, 6 and 7 always read 0, whatever is written to them.
- R9: While the enable is high, writes to bits 4 and 5 are ignored and the old values remain.
- R10: In mode 0 with a channel's select bit at 1, a rising edge on its trigger loads the count present before that edge into the channel register. Channel i reads at address 2+2i (low byte) and 3+2i (high byte). A trigger on a compare channel loads nothing.
- R11: A compare channel drives its match output high exactly while the enable is high and the count equals its register. This gives a one-cycle pulse per pass.
- R12: In modes 1-3 the select bits have no effect: every channel behaves as a compare channel and its triggers are ignored. In mode 0, a channel with select 1 never asserts match.
- R13: A read strobe at an edge makes the addressed byte appear on the read data port after that edge. The port holds its value until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counter enable |
| mode_i | input | 2 | 0 free-running, 1 pulse-width measurement, 2/3 other |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_bit_wr | input | 1 | Single-bit write strobe (option register only) |
| bus_bit_idx | input | 3 | Bit position for a single-bit write |
| bus_bit_val | input | 1 | Value for a single-bit write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| cap_trig | input | NUM_CH | Capture triggers, one per channel |
| cmp_match | output | NUM_CH | Compare match pulses, one per channel |
| count_o | output | CNT_W | Current count |
| ovf_irq | output | 1 | Overflow interrupt pulse |

## Verification
The overflow logic is tried in three regimes: a wrap in mode 0, a wrap in mode 1, and a long run through a wrap in mode 2. Together they separate the mode gating from the wrap detection itself. The flag is then hit with each clearing source on its own: reads, writes of 1 by byte and by bit, a write of 0, a dropped enable, and a clear placed on the wrap edge. This shows which sources really clear it and which one wins when they collide. The channels are driven in three settings: compare in mode 0, capture in mode 0, and capture-selected in mode 2. Each setting shows whether the select bit is honoured or overridden. The select bits are written while enabled and while disabled, and the reserved bits are written as ones.

// File: rtl/ftm_pkg.sv
package ftm_pkg;

   localparam int OPT_W = 8;

   typedef enum logic [1:0] {
      MODE_FREE  = 2'd0,
      MODE_PWM   = 2'd1,
      MODE_OTHA  = 2'd2,
      MODE_OTHB  = 2'd3
   } tmr_mode_e;

   function automatic logic ovf_mode_ok(input logic [1:0] m);
      return (m == MODE_FREE) || (m == MODE_PWM);
   endfunction

endpackage

// File: rtl/ftm_counter.sv
module ftm_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   output logic [CNT_W-1:0] count,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_w
      $error("ftm_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   count <= '0;
      else if (!en) count <= '0;
      else          count <= count + 1'b1;
   end

   assign wrap = en && (count == CNT_MAX);

   a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (count == '0));

   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && count != CNT_MAX) |=> (count == $past(count) + 1'b1));

   a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == '0));

endmodule

// File: rtl/ftm_optreg.sv
module ftm_optreg #(
   parameter int NUM_CH  = 2,
   parameter int SEL_LSB = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic              ovf_set,
   input  logic              byte_wr,
   input  logic [7:0]        wdata,
   input  logic              bit_wr,
   input  logic [2:0]        bit_idx,
   input  logic              bit_val,
   output logic              ovf_flag,
   output logic              ovf_irq,
   output logic [NUM_CH-1:0] sel,
   output logic [7:0]        reg_byte
);

   localparam int SEL_MSB = SEL_LSB + NUM_CH - 1;

   if (SEL_LSB < 1 || SEL_MSB > 7) begin : g_bad_sel
      $error("ftm_optreg: select field must lie within bits 1..7");
   end

   logic clr_req;
   logic unused_wbits;

   assign unused_wbits = ^wdata;

   assign clr_req = (byte_wr && !wdata[0])
                 || (bit_wr && bit_idx == 3'd0 && !bit_val)
                 || !cnt_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf_flag <= 1'b0;
         ovf_irq  <= 1'b0;
      end else begin
         ovf_irq <= ovf_set;
         if (ovf_set)      ovf_flag <= 1'b1;
         else if (clr_req) ovf_flag <= 1'b0;
      end
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      logic cand;
      always_comb begin
         cand = sel[i];
         if (byte_wr)
            cand = wdata[SEL_LSB+i];
         else if (bit_wr && bit_idx == 3'(SEL_LSB + i))
            cand = bit_val;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       sel[i] <= 1'b0;
         else if (!cnt_en) sel[i] <= cand;
      end
   end

   always_comb begin
      reg_byte = '0;
      reg_byte[0] = ovf_flag;
      reg_byte[SEL_MSB:SEL_LSB] = sel;
   end

   a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |=> ovf_flag);

   a_r4_irq_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> ovf_flag);

   a_r4_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_irq && !ovf_set) |=> !ovf_irq);

   a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !ovf_set) |=> !ovf_flag);

   a_r9_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_en |=> $stable(sel));

   a_r6_no_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_flag && !ovf_set) |=> !ovf_flag);

endmodule

// File: rtl/ftm_channel.sv
module ftm_channel #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic             cnt_en,
   input  logic             cap_mode,
   input  logic             trig,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [7:0]       wdata,
   output logic [CNT_W-1:0] value,
   output logic             match
);

   if (CNT_W > 16) begin : g_bad_w
      $error("ftm_channel: CNT_W must not exceed 16");
   end

   logic        trig_q;
   logic        rise;
   logic [15:0] val16;
   logic [15:0] nxt16;

   assign rise  = trig && !trig_q;
   assign val16 = 16'(value);

   always_comb begin
      nxt16 = val16;
      if (wr_lo) nxt16[7:0]  = wdata;
      if (wr_hi) nxt16[15:8] = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q <= 1'b0;
         value  <= '0;
      end else begin
         trig_q <= trig;
         if (cap_mode && rise)    value <= count;
         else if (wr_lo || wr_hi) value <= nxt16[CNT_W-1:0];
      end
   end

   assign match = cnt_en && !cap_mode && (count == value);

   a_r10_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_mode && trig && !trig_q) |=> (value == $past(count)));

   a_r11_match_single: assert property (@(posedge clk) disable iff (!rst_n)
      (match && !wr_lo && !wr_hi) |=> !match);

   a_r12_cap_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      cap_mode |-> !match);

endmodule

// File: rtl/ftmr_top.sv
module ftmr_top #(
   parameter int CNT_W   = 16,
   parameter int NUM_CH  = 2,
   parameter int SEL_LSB = 4,
   parameter int ADDR_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cnt_en,
   input  logic [1:0]        mode_i,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   input  logic              bus_bit_wr,
   input  logic [2:0]        bus_bit_idx,
   input  logic              bus_bit_val,
   input  logic              bus_rd,
   output logic [7:0]        bus_rdata,
   input  logic [NUM_CH-1:0] cap_trig,
   output logic [NUM_CH-1:0] cmp_match,
   output logic [CNT_W-1:0]  count_o,
   output logic              ovf_irq
);

   import ftm_pkg::*;

   localparam int OPT_ADDR = 0;
   localparam int CH_BASE  = 2;
   localparam int N_ADDR   = CH_BASE + 2 * NUM_CH;

   if (N_ADDR > (1 << ADDR_W)) begin : g_bad_addr
      $error("ftmr_top: ADDR_W too small for NUM_CH channels");
   end
   if (NUM_CH < 1) begin : g_bad_ch
      $error("ftmr_top: NUM_CH must be at least 1");
   end

   logic              wrap;
   logic              ovf_set;
   logic              ovf_flag;
   logic [NUM_CH-1:0] sel;
   logic [7:0]        opt_byte;
   logic              opt_hit;
   logic [NUM_CH-1:0] cap_mode;
   logic [CNT_W-1:0]  ch_val [NUM_CH];
   logic [7:0]        rd_mux;

   assign opt_hit = (bus_addr == ADDR_W'(OPT_ADDR));
   assign ovf_set = wrap && ovf_mode_ok(mode_i);

   ftm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (cnt_en),
      .count (count_o),
      .wrap  (wrap)
   );

   ftm_optreg #(.NUM_CH(NUM_CH), .SEL_LSB(SEL_LSB)) u_opt (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_en   (cnt_en),
      .ovf_set  (ovf_set),
      .byte_wr  (bus_wr && opt_hit),
      .wdata    (bus_wdata),
      .bit_wr   (bus_bit_wr && opt_hit),
      .bit_idx  (bus_bit_idx),
      .bit_val  (bus_bit_val),
      .ovf_flag (ovf_flag),
      .ovf_irq  (ovf_irq),
      .sel      (sel),
      .reg_byte (opt_byte)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int LO_ADDR = CH_BASE + 2 * i;
      assign cap_mode[i] = (mode_i == MODE_FREE) && sel[i];
      ftm_channel #(.CNT_W(CNT_W)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .count    (count_o),
         .cnt_en   (cnt_en),
         .cap_mode (cap_mode[i]),
         .trig     (cap_trig[i]),
         .wr_lo    (bus_wr && bus_addr == ADDR_W'(LO_ADDR)),
         .wr_hi    (bus_wr && bus_addr == ADDR_W'(LO_ADDR + 1)),
         .wdata    (bus_wdata),
         .value    (ch_val[i]),
         .match    (cmp_match[i])
      );
   end

   always_comb begin
      rd_mux = '0;
      if (opt_hit) rd_mux = opt_byte;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_addr == ADDR_W'(CH_BASE + 2 * i))
            rd_mux = 8'(16'(ch_val[i]));
         if (bus_addr == ADDR_W'(CH_BASE + 2 * i + 1))
            rd_mux = 8'(16'(ch_val[i]) >> 8);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   a_r3_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> ovf_mode_ok($past(mode_i)));

   a_r3_irq_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_irq |-> (count_o == '0));

   a_r5_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && cnt_en && !bus_wr && !bus_bit_wr) |=> ovf_flag);

   a_r13_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/ftmr_top_tb.sv
module ftmr_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;
   localparam int NC = 2;
   localparam int MAXC = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cnt_en = 1'b0;
   logic [1:0]    mode_i = 2'd0;
   logic [2:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic [7:0]    bus_wdata = '0;
   logic          bus_bit_wr = 1'b0;
   logic [2:0]    bus_bit_idx = '0;
   logic          bus_bit_val = 1'b0;
   logic          bus_rd = 1'b0;
   logic [7:0]    bus_rdata;
   logic [NC-1:0] cap_trig = '0;
   logic [NC-1:0] cmp_match;
   logic [CW-1:0] count_o;
   logic          ovf_irq;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ftmr_top #(.CNT_W(CW), .NUM_CH(NC), .SEL_LSB(4), .ADDR_W(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode_i(mode_i),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .bus_bit_wr(bus_bit_wr), .bus_bit_idx(bus_bit_idx),
      .bus_bit_val(bus_bit_val), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .cap_trig(cap_trig), .cmp_match(cmp_match), .count_o(count_o),
      .ovf_irq(ovf_irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input int a, input int d);
      bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic bw(input int idx, input bit v);
      bus_addr = 3'd0; bus_bit_idx = 3'(idx); bus_bit_val = v; bus_bit_wr = 1'b1;
      tick();
      bus_bit_wr = 1'b0;
   endtask

   task automatic rd(input int a, output int d);
      bus_addr = 3'(a); bus_rd = 1'b1;
      tick();
      bus_rd = 1'b0;
      d = int'(bus_rdata);
   endtask

   task automatic wait_count(input int v);
      int guard = 0;
      while (int'(count_o) != v && guard < 4 * (MAXC + 1)) begin
         tick();
         guard++;
      end
   endtask

   task automatic t_reset();
      int d;
      chk("R1 count", int'(count_o), 0);
      chk("R1 irq", int'(ovf_irq), 0);
      rd(0, d);
      chk("R1 option", d, 8'h00);
      chk("R13 rdata hold", int'(bus_rdata), 8'h00);
   endtask

   task automatic t_count();
      mode_i = 2'd0; cnt_en = 1'b1;
      tick(); tick(); tick();
      chk("R2 count step", int'(count_o), 3);
      cnt_en = 1'b0;
      tick();
      chk("R2 hold zero", int'(count_o), 0);
   endtask

   task automatic t_reserved();
      int d;
      wr(0, 8'hFF);
      rd(0, d);
      chk("R8 reserved read 0, R6 write1 no set", d, 8'h30);
      bw(5, 1'b0);
      rd(0, d);
      chk("R8 bit write sel1", d, 8'h10);
      wr(0, 8'h00);
   endtask

   task automatic t_sel_lock();
      int d;
      wr(0, 8'h10);
      cnt_en = 1'b1;
      wr(0, 8'h20);
      bw(4, 1'b0);
      rd(0, d);
      chk("R9 sel locked", d, 8'h10);
      cnt_en = 1'b0;
      tick();
      wr(0, 8'h00);
      rd(0, d);
      chk("R9 sel writable when off", d, 8'h00);
   endtask

   task automatic t_ovf_free();
      int d;
      mode_i = 2'd0; cnt_en = 1'b1;
      wait_count(MAXC);
      chk("R4 no irq before wrap", int'(ovf_irq), 0);
      tick();
      chk("R2 wrap to zero", int'(count_o), 0);
      chk("R4 irq on wrap", int'(ovf_irq), 1);
      tick();
      chk("R4 irq one cycle", int'(ovf_irq), 0);
      rd(0, d);
      rd(0, d);
      chk("R3/R5 flag after reads", d & 1, 1);
      wr(0, 8'h01);
      bw(0, 1'b1);
      rd(0, d);
      chk("R6 write1 keeps", d & 1, 1);
      bw(0, 1'b0);
      rd(0, d);
      chk("R6 write0 clears", d & 1, 0);
      wait_count(MAXC);
      bus_addr = 3'd0; bus_bit_idx = 3'd0; bus_bit_val = 1'b0; bus_bit_wr = 1'b1;
      tick();
      bus_bit_wr = 1'b0;
      chk("R7 irq on collision", int'(ovf_irq), 1);
      rd(0, d);
      chk("R7 set wins", d & 1, 1);
      cnt_en = 1'b0;
      tick();
      rd(0, d);
      chk("R6 disable clears", d & 1, 0);
   endtask

   task automatic t_ovf_pwm();
      int d;
      mode_i = 2'd1; cnt_en = 1'b1;
      wait_count(MAXC);
      tick();
      chk("R4 irq pwm", int'(ovf_irq), 1);
      rd(0, d);
      chk("R3 flag pwm", d & 1, 1);
      cnt_en = 1'b0;
      tick();
   endtask

   task automatic t_ovf_other();
      int d;
      int seen = 0;
      mode_i = 2'd2; cnt_en = 1'b1;
      for (int k = 0; k < MAXC + 20; k++) begin
         tick();
         if (ovf_irq) seen++;
      end
      chk("R4 no irq mode2", seen, 0);
      rd(0, d);
      chk("R3 no flag mode2", d & 1, 0);
      cnt_en = 1'b0;
      tick();
   endtask

   task automatic t_capture();
      int d;
      int c;
      wr(0, 8'h10);
      mode_i = 2'd0; cnt_en = 1'b1;
      tick(); tick(); tick(); tick(); tick();
      c = int'(count_o);
      cap_trig = 2'b11;
      tick();
      tick();
      cap_trig = 2'b00;
      rd(2, d);
      chk("R10 capture low", d, c);
      rd(3, d);
      chk("R10 capture high", d, 0);
      rd(4, d);
      chk("R10 compare chan no load", d, 0);
      cnt_en = 1'b0;
      tick();
   endtask

   task automatic t_compare();
      int d;
      wr(0, 8'h00);
      wr(4, 7);
      mode_i = 2'd0; cnt_en = 1'b1;
      wait_count(6);
      chk("R11 no match early", int'(cmp_match[1]), 0);
      tick();
      chk("R11 match", int'(cmp_match[1]), 1);
      tick();
      chk("R11 match one cycle", int'(cmp_match[1]), 0);
      cnt_en = 1'b0;
      tick();
      wr(0, 8'h10);
      wr(2, 9);
      mode_i = 2'd2; cnt_en = 1'b1;
      wait_count(9);
      chk("R12 sel ignored mode2 match", int'(cmp_match[0]), 1);
      wait_count(12);
      cap_trig[0] = 1'b1;
      tick();
      cap_trig[0] = 1'b0;
      rd(2, d);
      chk("R12 trig ignored mode2", d, 9);
      cnt_en = 1'b0;
      tick();
      mode_i = 2'd0; cnt_en = 1'b1;
      wait_count(9);
      chk("R12 capture chan no match", int'(cmp_match[0]), 0);
      cnt_en = 1'b0;
      tick();
      wr(0, 8'h00);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_count();
      t_reserved();
      t_sel_lock();
      t_ovf_free();
      t_ovf_pwm();
      t_ovf_other();
      t_capture();
      t_compare();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule